// File: doc/BRIEF.md
# I2S Sample Conditioner for a One-Bit Audio Modulator

This block sits between a stereo I2S receiver pin set and a free-running first-order one-bit modulator. It deserializes 24-bit two's-complement channel slots on the bit clock and keeps the top 16 bits of each. Once the right word of a frame completes, it passes the left and right values together to the fast modulator clock domain.

In the fast domain each signed value becomes an unsigned code centred on mid-scale. Bit 15 is inverted, which is the same as adding 32768 modulo 65536. The block holds the code until the next frame, so the modulator always integrates the most recent sample and never sees inserted zeros. A one-cycle strobe marks each update.

The two clock domains share one active-low reset. That reset is applied synchronously in each domain and must stay low across at least two edges of each clock.

Top module: `i2s_pcm_conditioner`

## Requirements
- R1: While reset is low and after it is released, before any complete frame arrives, both output codes are 0x8000 and the strobe is low.
- R2: Serial data is sampled on the rising bit-clock edge, MSB first. The first data bit is the one sampled on the edge after the edge where a word-select change is seen. Word-select low carries the left channel and high carries the right channel.
- R3: Only bits 23..8 of each 24-bit slot word reach the output, so changing the 8 low bits has no effect on the output codes.
- R4: The output code equals the truncated signed value plus 32768, modulo 65536. So 0 gives 0x8000, -32768 gives 0x0000, 32767 gives 0xFFFF and -1 gives 0x7FFF.
- R5: Between strobes both output codes hold their last value; they never return to zero or to mid-scale on their own.
- R6: Each completed right-channel word produces exactly one single-cycle strobe within 16 fast-clock cycles. Both channel codes take their new values in the same cycle the strobe is high.
- R7: A word cut short by a word-select change before its 24th data bit is discarded. A short left word leaves the previous left value in use, and a short right word produces no strobe. A slot whose transition lands on the 24th bit edge also counts as short.
- R8: Serial data sampled after the 24th bit of a slot, and on the transition edge itself, has no effect on the output codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_dac | input | 1 | Fast modulator clock |
| rst_n | input | 1 | Active-low reset, applied synchronously in both domains |
| i2s_sck | input | 1 | I2S bit clock |
| i2s_ws | input | 1 | I2S word select (0 = left, 1 = right) |
| i2s_sd | input | 1 | I2S serial data |
| left_code | output | 16 | Left channel offset-binary code |
| right_code | output | 16 | Right channel offset-binary code |
| sample_stb | output | 1 | One-cycle pulse when both codes update |

## Verification
A bit counter that slips by one position makes every code come out doubled or halved. That shows at the first strobe after the error, one frame later. A handshake that loses or repeats a toggle shows as a missing strobe within 16 fast cycles, or as an extra strobe with no completed frame behind it. The bench compares both codes on every fast clock, so a code that moves without a strobe is caught in the cycle it moves. A wrong offset or truncation shows in the extreme-value frames at their first strobe.

// File: rtl/i2s_cond_pkg.sv
// Shared types for the I2S sample conditioner.
// Assumes: channel index 0 is left and 1 is right throughout the block.
package i2s_cond_pkg;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/i2s_slot_rx.sv
// Bit-clock-domain receiver: deserializes I2S slots, keeps the upper
// OUT_W bits of each IN_W-bit word, and publishes a left/right pair with a
// toggle when a right word completes.
// Assumes: rst_n is held low across at least two rising sck edges; the
// published pair is stable for many fast-clock cycles after each toggle.
module i2s_slot_rx
    import i2s_cond_pkg::*;
#(
    parameter int IN_W  = 24,
    parameter int OUT_W = 16
) (
    input  logic             sck,
    input  logic             rst_n,
    input  logic             ws,
    input  logic             sd,
    output logic [OUT_W-1:0] pair_l,
    output logic [OUT_W-1:0] pair_r,
    output logic             pair_tgl
);
    localparam int CNT_W = $clog2(IN_W + 1);

    logic             ws_q;
    chan_e            cur_ch;
    logic [CNT_W-1:0] bit_cnt;
    logic [IN_W-2:0]  shreg;
    logic [OUT_W-1:0] left_hold;
    logic             ws_edge;
    logic             last_bit;
    logic [IN_W-1:0]  word_full;

    assign ws_edge   = (ws != ws_q);
    assign last_bit  = (bit_cnt == CNT_W'(IN_W - 1));
    assign word_full = {shreg, sd};

    // Remember word-select from the previous edge to spot transitions.
    always_ff @(posedge sck) begin
        if (!rst_n) ws_q <= 1'b1;
        else        ws_q <= ws;
    end

    // Count and shift data bits of the current slot; restart on a transition.
    always_ff @(posedge sck) begin
        if (!rst_n) begin
            bit_cnt <= CNT_W'(IN_W);
            cur_ch  <= CH_RIGHT;
            shreg   <= '0;
        end else if (ws_edge) begin
            bit_cnt <= '0;
            cur_ch  <= chan_e'(ws);
        end else if (bit_cnt < CNT_W'(IN_W)) begin
            shreg   <= {shreg[IN_W-3:0], sd};
            bit_cnt <= bit_cnt + CNT_W'(1);
        end
    end

    // Store completed words; a right word publishes the pair and flips the toggle.
    always_ff @(posedge sck) begin
        if (!rst_n) begin
            left_hold <= '0;
            pair_l    <= '0;
            pair_r    <= '0;
            pair_tgl  <= 1'b0;
        end else if (!ws_edge && last_bit) begin
            if (cur_ch == CH_LEFT) begin
                left_hold <= word_full[IN_W-1 -: OUT_W];
            end else begin
                pair_l   <= left_hold;
                pair_r   <= word_full[IN_W-1 -: OUT_W];
                pair_tgl <= ~pair_tgl;
            end
        end
    end

    AST_WS_RESTART: assert property (@(posedge sck) disable iff (!rst_n)
        ws_edge |=> (bit_cnt == '0)); // R2

    AST_CNT_BOUND: assert property (@(posedge sck) disable iff (!rst_n)
        bit_cnt <= CNT_W'(IN_W)); // R8

    AST_TGL_RIGHT: assert property (@(posedge sck) disable iff (!rst_n)
        (pair_tgl != $past(pair_tgl)) |-> ($past(cur_ch) == CH_RIGHT && $past(last_bit) && !$past(ws_edge))); // R6

endmodule

// File: rtl/pulse_toggle_sync.sv
// Fast-domain toggle synchronizer: turns each change of a slow toggle into
// a one-cycle pulse.
// Assumes: the toggle changes far less often than STAGES+1 fast cycles.
module pulse_toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic pulse
);
    logic [STAGES-1:0] chain;
    logic              seen_q;

    // Resynchronize the toggle through a flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], tgl_in};
    end

    // Keep the last synchronized level to detect a change.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= chain[STAGES-1];
    end

    assign pulse = chain[STAGES-1] ^ seen_q;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse); // R6

endmodule

// File: rtl/pcm_offset_out.sv
// Fast-domain output stage: converts each signed channel value to
// offset binary and holds it until the next load.
// Assumes: sgn_in is stable whenever load is high.
module pcm_offset_out #(
    parameter int W   = 16,
    parameter int NCH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] sgn_in   [NCH],
    output logic [W-1:0] code_out [NCH],
    output logic         stb
);
    localparam logic [W-1:0] MID = W'(1) << (W - 1);

    logic [W-1:0] conv   [NCH];
    logic [W-1:0] code_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign conv[g]     = {~sgn_in[g][W-1], sgn_in[g][W-2:0]};
        assign code_out[g] = code_q[g];

        AST_OFFSET_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            stb |-> (code_q[g] == W'($past(sgn_in[g]) + (1 << (W - 1))))); // R4

        AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
            (code_q[g] != $past(code_q[g])) |-> stb); // R5
    end

    // Hold the latest codes; reload them only on a synchronized update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) code_q[i] <= MID;
        end else if (load) begin
            for (int i = 0; i < NCH; i++) code_q[i] <= conv[i];
        end
    end

    // Flag the cycle in which new codes appear.
    always_ff @(posedge clk) begin
        if (!rst_n) stb <= 1'b0;
        else        stb <= load;
    end

endmodule

// File: rtl/i2s_pcm_conditioner.sv
// Top: I2S stereo receiver feeding offset-binary, held codes into a fast
// modulator clock domain through a toggle handshake.
// Assumes: rst_n low across two edges of both i2s_sck and clk_dac; the
// fast clock is several times faster than the bit clock.
module i2s_pcm_conditioner
    import i2s_cond_pkg::*;
#(
    parameter int IN_W        = 24,
    parameter int OUT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_dac,
    input  logic             rst_n,
    input  logic             i2s_sck,
    input  logic             i2s_ws,
    input  logic             i2s_sd,
    output logic [OUT_W-1:0] left_code,
    output logic [OUT_W-1:0] right_code,
    output logic             sample_stb
);
    logic [OUT_W-1:0] pair_l;
    logic [OUT_W-1:0] pair_r;
    logic             pair_tgl;
    logic             load;
    logic [OUT_W-1:0] sgn_pair  [NUM_CH];
    logic [OUT_W-1:0] code_pair [NUM_CH];

    i2s_slot_rx #(.IN_W(IN_W), .OUT_W(OUT_W)) u_rx (
        .sck      (i2s_sck),
        .rst_n    (rst_n),
        .ws       (i2s_ws),
        .sd       (i2s_sd),
        .pair_l   (pair_l),
        .pair_r   (pair_r),
        .pair_tgl (pair_tgl)
    );

    pulse_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk_dac),
        .rst_n  (rst_n),
        .tgl_in (pair_tgl),
        .pulse  (load)
    );

    assign sgn_pair[CH_LEFT]  = pair_l;
    assign sgn_pair[CH_RIGHT] = pair_r;

    pcm_offset_out #(.W(OUT_W), .NCH(NUM_CH)) u_out (
        .clk      (clk_dac),
        .rst_n    (rst_n),
        .load     (load),
        .sgn_in   (sgn_pair),
        .code_out (code_pair),
        .stb      (sample_stb)
    );

    assign left_code  = code_pair[CH_LEFT];
    assign right_code = code_pair[CH_RIGHT];

endmodule

// File: tb/sim_i2s_pcm_conditioner.sv
module sim_i2s_pcm_conditioner;

    typedef struct {
        logic [15:0] l;
        logic [15:0] r;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        sck = 1'b0;
    logic        rst_n = 1'b0;
    logic        ws = 1'b1;
    logic        sd = 1'b0;
    logic [15:0] left_code;
    logic [15:0] right_code;
    logic        sample_stb;

    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;
    int          wait_cnt = 0;
    bit          mon_en = 1'b0;
    exp_t        q[$];
    logic [15:0] cur_l = 16'h8000;
    logic [15:0] cur_r = 16'h8000;
    logic [15:0] left_last = 16'h8000;
    string       cur_tag = "R2";
    logic [31:0] lcg = 32'h1234_5678;

    i2s_pcm_conditioner u0 (
        .clk_dac    (clk),
        .rst_n      (rst_n),
        .i2s_sck    (sck),
        .i2s_ws     (ws),
        .i2s_sd     (sd),
        .left_code  (left_code),
        .right_code (right_code),
        .sample_stb (sample_stb)
    );

    always #5 clk = ~clk;
    always #40 sck = ~sck;

    // Expected unsigned code of a 24-bit slot word, by arithmetic.
    function automatic logic [15:0] code_of(input logic [23:0] d);
        int s;
        s = int'($signed(d[23:8]));
        return 16'(s + 32768);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Drive one slot; data bits start on the edge after the transition edge.
    task automatic send_slot(input logic ch, input logic [23:0] data,
                             input int slot_len, input logic pad, input string tag);
        exp_t e;
        for (int i = 0; i < slot_len; i++) begin
            @(negedge sck);
            ws = ch;
            if (i >= 1 && i <= 24) sd = data[24-i];
            else                   sd = pad;
            if (i == 24) begin
                if (ch == 1'b0) begin
                    left_last = code_of(data);
                end else begin
                    e.l = left_last;
                    e.r = code_of(data);
                    e.tag = tag;
                    q.push_back(e);
                end
            end
        end
    endtask

    task automatic frame(input logic [23:0] l, input logic [23:0] r,
                         input logic pad, input string tag);
        send_slot(1'b0, l, 32, pad, tag);
        send_slot(1'b1, r, 32, pad, tag);
    endtask

    // Reference comparison on every fast clock, away from the active edge.
    always @(negedge clk) begin
        if (mon_en) begin
            if (sample_stb) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R6", "strobe without completed frame", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(left_code == e.l, e.tag, "left code", int'(left_code), int'(e.l));
                    chk(right_code == e.r, e.tag, "right code", int'(right_code), int'(e.r));
                    cur_l = e.l;
                    cur_r = e.r;
                end
                wait_cnt = 0;
            end else begin
                chk(left_code == cur_l && right_code == cur_r, "R5", "held codes",
                    int'({left_code, right_code}), int'({cur_l, cur_r}));
                if (q.size() > 0) begin
                    wait_cnt++;
                    if (wait_cnt > 16) begin
                        exp_t e;
                        chk(1'b0, "R6", "strobe latency", wait_cnt, 16);
                        e = q.pop_front();
                        cur_l = e.l;
                        cur_r = e.r;
                        wait_cnt = 0;
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (30) @(negedge clk);
        // R1: state while reset is held
        chk(left_code == 16'h8000, "R1", "left in reset", int'(left_code), 16'h8000);
        chk(right_code == 16'h8000, "R1", "right in reset", int'(right_code), 16'h8000);
        chk(sample_stb == 1'b0, "R1", "strobe in reset", int'(sample_stb), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        // R1: state after release, before any frame
        chk(left_code == 16'h8000 && right_code == 16'h8000, "R1", "codes after reset",
            int'({left_code, right_code}), 32'h8000_8000);
        chk(sample_stb == 1'b0, "R1", "strobe after reset", int'(sample_stb), 0);
        mon_en = 1'b1;

        frame(24'h000000, 24'h000000, 1'b0, "R4");     // silence -> mid-scale
        frame(24'h7FFFFF, 24'h800000, 1'b0, "R4");     // extremes
        frame(24'hFFFFFF, 24'h000100, 1'b0, "R4");     // -1 and +1
        frame(24'h1234FF, 24'h123400, 1'b0, "R3");     // low byte ignored
        frame(24'h5A5A5A, 24'hC3C3C3, 1'b0, "R2");     // bit order and channels
        frame(24'h0000FF, 24'h000000, 1'b1, "R8");     // padding ones ignored

        // R7: short left word (12 data bits) keeps the previous left value
        send_slot(1'b0, 24'h7FFF00, 13, 1'b0, "R7");
        send_slot(1'b1, 24'h400000, 32, 1'b0, "R7");
        // R7: transition on the 24th bit edge is still short
        send_slot(1'b0, 24'h200000, 24, 1'b0, "R7");
        send_slot(1'b1, 24'hE00000, 32, 1'b0, "R7");
        // R7: short right word gives no strobe
        send_slot(1'b0, 24'h100000, 32, 1'b0, "R7");
        send_slot(1'b1, 24'h7F0000, 13, 1'b0, "R7");
        send_slot(1'b0, 24'h200000, 32, 1'b0, "R7");
        send_slot(1'b1, 24'h300000, 32, 1'b0, "R7");

        for (int k = 0; k < 16; k++) begin
            logic [23:0] a;
            logic [23:0] b;
            lcg = lcg * 32'd1103515245 + 32'd12345;
            a = lcg[31:8];
            lcg = lcg * 32'd1103515245 + 32'd12345;
            b = lcg[31:8];
            frame(a, b, k[0], "R2");
        end

        repeat (300) @(negedge clk);   // R5: long idle, codes must hold
        chk(q.size() == 0, "R6", "frames left without strobe", q.size(), 0);
        mon_en = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule